// File: doc/BRIEF.md
# PLL Rate-Change Sequencer

This block owns the 32-bit control and status word of a clock synthesizer. It changes the synthesizer's rate safely. A rate request carries a new feedback multiplier code and a new post-divider code. The sequencer compares the requested multiplier code with the one currently programmed and picks one of two paths:

- **Equal codes:** a short path. The output is parked on the reference clock, the post-divider is swapped, and the output is released again.
- **Different codes:** a full relock path. The output is parked on the reference, the loop is held in reset, both divider fields are rewritten, reset is released, and the sequencer waits for the coarse lock flag and then for the late lock flag. The output is then enabled and unparked in a single update.

A separate entry point powers the loop up: it releases reset and waits for both lock flags. Other one-cycle commands power the loop down and gate the output on or off. A programmable watchdog aborts a lock wait that runs too long. On an abort the block flags an error and leaves the output parked on the reference.

The analog loop lies outside the block. Its two lock flags arrive as inputs, and the range field is fixed by a parameter.

Top module: `pll_reconfig_seq`

## Requirements
- R1: After reset the word holds multiplier code FB_INIT, post-divider OD_INIT, reset bit 1, external bypass 1 and enable 0. Busy, done and error are 0.
- R2: The control word decodes as follows, and every other bit reads 0:
  - bit 29: mirrors the late lock input.
  - bit 28: mirrors the lock input.
  - bits 27:20: the multiplier code.
  - bits 18:16: the post-divider code.
  - bits 6:4: the range code RANGE_CODE.
  - bit 3: internal bypass, always 0.
  - bit 2: loop reset.
  - bit 1: external bypass.
  - bit 0: output enable.
- R3: The full relock path runs one step per cycle after the accepting edge. Bypass is set first. Reset rises on the next edge. Both divider fields change on the edge after that, while reset is still high. Reset falls on the following edge.
- R4: After reset is released, the sequencer first waits for the lock input. Only once lock has been seen does it wait for the late lock input. A late lock flag that arrives before lock does not end the wait.
- R5: On the edge after late lock is seen, the relock path sets enable and clears bypass together, and pulses done.
- R6: The short path runs one step per cycle. Bypass is set on the accepting edge. The post-divider changes on the next edge. Bypass clears and done pulses on the edge after that. Reset never changes and no lock is awaited.
- R7: Prepare clears the reset bit, waits for lock and then late lock, and pulses done, leaving enable and bypass untouched. Unprepare sets the reset bit on the next edge. Enable and disable set or clear bit 0 on the next edge. None of these three commands pulses done.
- R8: Busy is high from the accepting edge until the edge that pulses done. Done lasts one cycle and is never high together with busy. Every request that arrives while busy is ignored.
- R9: With a limit N other than 0, a wait state that sees N consecutive cycles without its awaited flag aborts. The abort sets error and bypass, pulses done and drops busy. A limit of 0 waits forever. Accepting the next rate or prepare request clears error.
- R10: When several commands arrive together while idle, the rate request wins over prepare, prepare over unprepare, unprepare over enable, and enable over disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rate_req_i | input | 1 | Rate change strobe |
| rate_fb_i | input | 8 | Requested multiplier code |
| rate_od_i | input | 3 | Requested post-divider code |
| prep_req_i | input | 1 | Power-up (release reset and wait for lock) strobe |
| unprep_req_i | input | 1 | Power-down (assert reset) strobe |
| en_req_i | input | 1 | Output enable strobe |
| dis_req_i | input | 1 | Output disable strobe |
| tmo_limit_i | input | TMO_W | Lock wait limit in cycles, 0 = none |
| pll_lock_i | input | 1 | Coarse lock flag from the loop |
| pll_late_lock_i | input | 1 | Late lock flag from the loop |
| pll_ctrl_o | output | 32 | Control and status word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last lock wait timed out |

## Verification
The assertions assume the following:

- The lock flags fall whenever the reset bit is high.
- Commands arrive as single-cycle strobes.
- The timeout limit stays constant while a wait state is active.

The bench honours these assumptions. Its loop model derives both flags from the reset bit the block drives and clears them whenever reset is high. It drives every command for exactly one cycle, away from the clock edge. It changes the limit only while the block is idle. One deliberate exception is a mode in which late lock rises before lock, used to exercise the ordering rule.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
   localparam int REG_W     = 32;
   localparam int FB_W      = 8;
   localparam int OD_W      = 3;
   localparam int RANGE_W   = 3;
   localparam int FB_LSB    = 20;
   localparam int OD_LSB    = 16;
   localparam int RANGE_LSB = 4;
   localparam int BIT_LATE  = 29;
   localparam int BIT_LOCK  = 28;
   localparam int BIT_IBYP  = 3;
   localparam int BIT_RST   = 2;
   localparam int BIT_XBYP  = 1;
   localparam int BIT_XEN   = 0;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ASSERT_RST,
      ST_PROGRAM,
      ST_RELEASE,
      ST_WAIT_LOCK,
      ST_WAIT_LATE,
      ST_FAST_DIV,
      ST_FAST_END
   } seq_state_t;

   typedef struct packed {
      logic [FB_W-1:0] fb;
      logic [OD_W-1:0] od;
      logic            rst;
      logic            xbyp;
      logic            xen;
   } pll_ctl_t;
endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
   parameter int STAGES = 0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lock_i,
   input  logic late_i,
   output logic lock_o,
   output logic late_o
);
   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
         $error("pll_lock_sync: STAGES must lie in 0..4");
      end
      if (STAGES == 0) begin : g_direct
         assign lock_o = lock_i;
         assign late_o = late_i;
      end else begin : g_sync
         logic [STAGES-1:0] lock_sh;
         logic [STAGES-1:0] late_sh;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               lock_sh <= '0;
               late_sh <= '0;
            end else begin
               lock_sh <= {lock_sh[STAGES-1:0], lock_i} >> 0;
               late_sh <= {late_sh[STAGES-1:0], late_i} >> 0;
            end
         end
         assign lock_o = lock_sh[STAGES-1];
         assign late_o = late_sh[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
   parameter int TMO_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [TMO_W-1:0] limit_i,
   output logic             expired_o
);
   logic [TMO_W-1:0] cnt_q;

   generate
      if (TMO_W < 2 || TMO_W > 32) begin : g_bad_width
         $error("pll_lock_timer: TMO_W must lie in 2..32");
      end
   endgenerate

   assign expired_o = run_i && (limit_i != '0) && (cnt_q == limit_i - TMO_W'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  cnt_q <= '0;
      else if (!run_i || expired_o) cnt_q <= '0;
      else                          cnt_q <= cnt_q + TMO_W'(1);
   end

   AST_TIMER_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (limit_i != '0 && $stable(limit_i)) |-> (cnt_q < limit_i)); // R9
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
   import pll_seq_pkg::*;
#(
   parameter int FB_INIT = 32,
   parameter int OD_INIT = 1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            rate_req_i,
   input  logic [FB_W-1:0] rate_fb_i,
   input  logic [OD_W-1:0] rate_od_i,
   input  logic            prep_req_i,
   input  logic            unprep_req_i,
   input  logic            en_req_i,
   input  logic            dis_req_i,
   input  logic            lock_i,
   input  logic            late_i,
   input  logic            expired_i,
   output logic            run_o,
   output pll_ctl_t        ctl_o,
   output logic            busy_o,
   output logic            done_o,
   output logic            err_o
);
   localparam logic [FB_W-1:0] FB_RST = FB_W'(FB_INIT);
   localparam logic [OD_W-1:0] OD_RST = OD_W'(OD_INIT);

   generate
      if (FB_INIT < 0 || FB_INIT >= (1 << FB_W)) begin : g_bad_fb
         $error("pll_seq_fsm: FB_INIT out of range");
      end
      if (OD_INIT < 0 || OD_INIT >= (1 << OD_W)) begin : g_bad_od
         $error("pll_seq_fsm: OD_INIT out of range");
      end
   endgenerate

   seq_state_t      state_q;
   pll_ctl_t        ctl_q;
   logic [FB_W-1:0] pend_fb_q;
   logic [OD_W-1:0] pend_od_q;
   logic            prep_mode_q;
   logic            done_q;
   logic            err_q;

   assign run_o = (state_q == ST_WAIT_LOCK && !lock_i) ||
                  (state_q == ST_WAIT_LATE && !late_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q     <= ST_IDLE;
         ctl_q       <= '{fb: FB_RST, od: OD_RST, rst: 1'b1, xbyp: 1'b1, xen: 1'b0};
         pend_fb_q   <= '0;
         pend_od_q   <= '0;
         prep_mode_q <= 1'b0;
         done_q      <= 1'b0;
         err_q       <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (rate_req_i) begin
                  pend_fb_q   <= rate_fb_i;
                  pend_od_q   <= rate_od_i;
                  err_q       <= 1'b0;
                  prep_mode_q <= 1'b0;
                  ctl_q.xbyp  <= 1'b1;
                  state_q     <= (rate_fb_i != ctl_q.fb) ? ST_ASSERT_RST : ST_FAST_DIV;
               end else if (prep_req_i) begin
                  err_q       <= 1'b0;
                  prep_mode_q <= 1'b1;
                  ctl_q.rst   <= 1'b0;
                  state_q     <= ST_WAIT_LOCK;
               end else if (unprep_req_i) begin
                  ctl_q.rst   <= 1'b1;
               end else if (en_req_i) begin
                  ctl_q.xen   <= 1'b1;
               end else if (dis_req_i) begin
                  ctl_q.xen   <= 1'b0;
               end
            end
            ST_ASSERT_RST: begin
               ctl_q.rst <= 1'b1;
               state_q   <= ST_PROGRAM;
            end
            ST_PROGRAM: begin
               ctl_q.fb <= pend_fb_q;
               ctl_q.od <= pend_od_q;
               state_q  <= ST_RELEASE;
            end
            ST_RELEASE: begin
               ctl_q.rst <= 1'b0;
               state_q   <= ST_WAIT_LOCK;
            end
            ST_WAIT_LOCK: begin
               if (lock_i) begin
                  state_q <= ST_WAIT_LATE;
               end else if (expired_i) begin
                  err_q      <= 1'b1;
                  ctl_q.xbyp <= 1'b1;
                  done_q     <= 1'b1;
                  state_q    <= ST_IDLE;
               end
            end
            ST_WAIT_LATE: begin
               if (late_i) begin
                  if (!prep_mode_q) begin
                     ctl_q.xen  <= 1'b1;
                     ctl_q.xbyp <= 1'b0;
                  end
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (expired_i) begin
                  err_q      <= 1'b1;
                  ctl_q.xbyp <= 1'b1;
                  done_q     <= 1'b1;
                  state_q    <= ST_IDLE;
               end
            end
            ST_FAST_DIV: begin
               ctl_q.od <= pend_od_q;
               state_q  <= ST_FAST_END;
            end
            ST_FAST_END: begin
               ctl_q.xbyp <= 1'b0;
               done_q     <= 1'b1;
               state_q    <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign ctl_o  = ctl_q;
   assign busy_o = (state_q != ST_IDLE);
   assign done_o = done_q;
   assign err_o  = err_q;

   AST_LATE_AFTER_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_WAIT_LATE && $past(state_q) == ST_WAIT_LOCK) |-> $past(lock_i)); // R4
   AST_FAST_KEEPS_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_FAST_DIV || state_q == ST_FAST_END) |-> $stable(ctl_q.rst)); // R6
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |=> !done_q); // R8
endmodule

// File: rtl/pll_reg_pack.sv
module pll_reg_pack
   import pll_seq_pkg::*;
#(
   parameter int RANGE_CODE = 2
) (
   input  pll_ctl_t         ctl_i,
   input  logic             lock_i,
   input  logic             late_i,
   output logic [REG_W-1:0] word_o
);
   generate
      if (RANGE_CODE < 0 || RANGE_CODE >= (1 << RANGE_W)) begin : g_bad_range
         $error("pll_reg_pack: RANGE_CODE out of range");
      end
   endgenerate

   always_comb begin
      word_o                            = '0;
      word_o[BIT_LATE]                  = late_i;
      word_o[BIT_LOCK]                  = lock_i;
      word_o[FB_LSB +: FB_W]            = ctl_i.fb;
      word_o[OD_LSB +: OD_W]            = ctl_i.od;
      word_o[RANGE_LSB +: RANGE_W]      = RANGE_W'(RANGE_CODE);
      word_o[BIT_IBYP]                  = 1'b0;
      word_o[BIT_RST]                   = ctl_i.rst;
      word_o[BIT_XBYP]                  = ctl_i.xbyp;
      word_o[BIT_XEN]                   = ctl_i.xen;
   end
endmodule

// File: rtl/pll_reconfig_seq.sv
module pll_reconfig_seq
   import pll_seq_pkg::*;
#(
   parameter int FB_INIT    = 32,
   parameter int OD_INIT    = 1,
   parameter int RANGE_CODE = 2,
   parameter int TMO_W      = 16,
   parameter int SYNC_STG   = 0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             rate_req_i,
   input  logic [7:0]       rate_fb_i,
   input  logic [2:0]       rate_od_i,
   input  logic             prep_req_i,
   input  logic             unprep_req_i,
   input  logic             en_req_i,
   input  logic             dis_req_i,
   input  logic [TMO_W-1:0] tmo_limit_i,
   input  logic             pll_lock_i,
   input  logic             pll_late_lock_i,
   output logic [31:0]      pll_ctrl_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             err_o
);
   logic     lock_s;
   logic     late_s;
   logic     run;
   logic     expired;
   pll_ctl_t ctl;

   pll_lock_sync #(.STAGES(SYNC_STG)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lock_i (pll_lock_i),
      .late_i (pll_late_lock_i),
      .lock_o (lock_s),
      .late_o (late_s)
   );

   pll_lock_timer #(.TMO_W(TMO_W)) u_timer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run),
      .limit_i   (tmo_limit_i),
      .expired_o (expired)
   );

   pll_seq_fsm #(.FB_INIT(FB_INIT), .OD_INIT(OD_INIT)) u_fsm (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .rate_req_i   (rate_req_i),
      .rate_fb_i    (rate_fb_i),
      .rate_od_i    (rate_od_i),
      .prep_req_i   (prep_req_i),
      .unprep_req_i (unprep_req_i),
      .en_req_i     (en_req_i),
      .dis_req_i    (dis_req_i),
      .lock_i       (lock_s),
      .late_i       (late_s),
      .expired_i    (expired),
      .run_o        (run),
      .ctl_o        (ctl),
      .busy_o       (busy_o),
      .done_o       (done_o),
      .err_o        (err_o)
   );

   pll_reg_pack #(.RANGE_CODE(RANGE_CODE)) u_pack (
      .ctl_i  (ctl),
      .lock_i (pll_lock_i),
      .late_i (pll_late_lock_i),
      .word_o (pll_ctrl_o)
   );

   AST_DIV_UNDER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(pll_ctrl_o[27:20]) |-> pll_ctrl_o[2]); // R3
   AST_UNPARK_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pll_ctrl_o[1]) |-> done_o); // R5
   AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o); // R8
   AST_ERR_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> pll_ctrl_o[1]); // R9
endmodule

// File: tb/pll_reconfig_seq_test.sv
module pll_reconfig_seq_test;
   localparam int FB_INIT = 32;
   localparam int OD_INIT = 1;
   localparam int RANGE   = 2;
   localparam int LOCK_DLY = 6;
   localparam int LATE_DLY = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rate_req = 1'b0;
   logic [7:0]  rate_fb = '0;
   logic [2:0]  rate_od = '0;
   logic        prep_req = 1'b0;
   logic        unprep_req = 1'b0;
   logic        en_req = 1'b0;
   logic        dis_req = 1'b0;
   logic [15:0] tmo_limit = '0;
   logic        pll_lock;
   logic        pll_late;
   logic [31:0] pll_ctrl;
   logic        busy;
   logic        done;
   logic        err;

   int n_chk = 0;
   int n_fail = 0;
   bit kill = 1'b0;
   bit late_first = 1'b0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   pll_reconfig_seq uut (
      .clk_i (clk), .rst_ni (rst_n),
      .rate_req_i (rate_req), .rate_fb_i (rate_fb), .rate_od_i (rate_od),
      .prep_req_i (prep_req), .unprep_req_i (unprep_req),
      .en_req_i (en_req), .dis_req_i (dis_req),
      .tmo_limit_i (tmo_limit),
      .pll_lock_i (pll_lock), .pll_late_lock_i (pll_late),
      .pll_ctrl_o (pll_ctrl), .busy_o (busy), .done_o (done), .err_o (err)
   );

   // analog loop model
   int lk_cnt;
   always @(posedge clk) begin
      if (!rst_n || pll_ctrl[2] || kill) begin
         lk_cnt   <= 0;
         pll_lock <= 1'b0;
         pll_late <= 1'b0;
      end else begin
         if (lk_cnt < 1000) lk_cnt <= lk_cnt + 1;
         pll_lock <= (lk_cnt >= LOCK_DLY);
         pll_late <= late_first ? 1'b1 : (lk_cnt >= LOCK_DLY + LATE_DLY);
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   int m_ph, m_wait, m_fb, m_od, m_rst, m_byp, m_ena, m_done, m_err, m_prep, p_fb, p_od;
   task automatic m_abort();
      m_err = 1; m_byp = 1; m_done = 1; m_ph = 0;
   endtask
   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_wait = 0; m_fb = FB_INIT; m_od = OD_INIT; m_rst = 1; m_byp = 1;
         m_ena = 0; m_done = 0; m_err = 0; m_prep = 0; p_fb = 0; p_od = 0;
      end else begin
         m_done = 0;
         case (m_ph)
            0: begin
               if (rate_req) begin
                  p_fb = rate_fb; p_od = rate_od; m_err = 0; m_byp = 1; m_prep = 0; m_wait = 0;
                  m_ph = (int'(rate_fb) != m_fb) ? 1 : 6;
               end else if (prep_req) begin
                  m_rst = 0; m_prep = 1; m_err = 0; m_wait = 0; m_ph = 4;
               end else if (unprep_req) m_rst = 1;
               else if (en_req) m_ena = 1;
               else if (dis_req) m_ena = 0;
            end
            1: begin m_rst = 1; m_ph = 2; end
            2: begin m_fb = p_fb; m_od = p_od; m_ph = 3; end
            3: begin m_rst = 0; m_wait = 0; m_ph = 4; end
            4: begin
               if (pll_lock) begin m_ph = 5; m_wait = 0; end
               else if (tmo_limit != 0 && m_wait + 1 == int'(tmo_limit)) m_abort();
               else m_wait++;
            end
            5: begin
               if (pll_late) begin
                  if (!m_prep) begin m_ena = 1; m_byp = 0; end
                  m_done = 1; m_ph = 0;
               end else if (tmo_limit != 0 && m_wait + 1 == int'(tmo_limit)) m_abort();
               else m_wait++;
            end
            6: begin m_od = p_od; m_ph = 7; end
            7: begin m_byp = 0; m_done = 1; m_ph = 0; end
            default: m_ph = 0;
         endcase
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         longint exp_w;
         exp_w = (longint'(pll_late) << 29) | (longint'(pll_lock) << 28) | (longint'(m_fb) << 20) |
                 (longint'(m_od) << 16) | (longint'(RANGE) << 4) | (longint'(m_rst) << 2) |
                 (longint'(m_byp) << 1) | longint'(m_ena);
         chk(pll_ctrl == exp_w[31:0], "R2 word", pll_ctrl, exp_w);
         chk(busy == (m_ph != 0), "R8 busy", busy, m_ph != 0);
         chk(done == m_done[0], "R8 done", done, m_done);
         chk(err == m_err[0], "R9 err", err, m_err);
      end
   end

   task automatic summary();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000 && !finished) begin
         chk(1'b0, "watchdog", cyc, 50000);
         summary();
      end
   end

   // one-cycle strobe; returns at the negedge after the accepting edge
   task automatic strobe(input int kind, input int fb, input int od);
      @(negedge clk);
      rate_fb = 8'(fb); rate_od = 3'(od);
      rate_req   = (kind & 1) != 0;
      prep_req   = (kind & 2) != 0;
      unprep_req = (kind & 4) != 0;
      en_req     = (kind & 8) != 0;
      dis_req    = (kind & 16) != 0;
      @(negedge clk);
      rate_req = 0; prep_req = 0; unprep_req = 0; en_req = 0; dis_req = 0;
   endtask

   task automatic wait_done(input string tag);
      int n = 0;
      while (!done && n < 2000) begin @(negedge clk); n++; end
      chk(done, tag, done, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(pll_ctrl[27:20] == 8'(FB_INIT) && pll_ctrl[18:16] == 3'(OD_INIT), "R1 dividers", pll_ctrl, 0);
      chk(pll_ctrl[2:0] == 3'b110 && !busy && !done && !err, "R1 control bits", pll_ctrl[2:0], 3'b110);
      rst_n = 1'b1;
      tmo_limit = 16'd100;

      // R7 prepare
      strobe(2, 0, 0);
      chk(pll_ctrl[2] == 1'b0 && busy, "R7 prepare releases reset", pll_ctrl[2], 0);
      wait_done("R7 prepare done");
      chk(pll_ctrl[1:0] == 2'b10, "R7 prepare keeps enable/bypass", pll_ctrl[1:0], 2'b10);
      @(negedge clk);

      // R7 enable / disable
      strobe(8, 0, 0);
      chk(pll_ctrl[0] == 1'b1 && !done, "R7 enable", pll_ctrl[0], 1);
      strobe(16, 0, 0);
      chk(pll_ctrl[0] == 1'b0, "R7 disable", pll_ctrl[0], 0);
      strobe(8, 0, 0);

      // R6 short path with a disable request while busy (R8)
      strobe(1, FB_INIT, 5);
      chk(pll_ctrl[1] && pll_ctrl[18:16] == 3'(OD_INIT) && !pll_ctrl[2], "R6 step1 bypass", pll_ctrl, 0);
      dis_req = 1;
      @(negedge clk);
      dis_req = 0;
      chk(pll_ctrl[1] && pll_ctrl[18:16] == 3'd5 && !pll_ctrl[2], "R6 step2 divider", pll_ctrl[18:16], 5);
      @(negedge clk);
      chk(!pll_ctrl[1] && done && !pll_ctrl[2], "R6 step3 unpark", pll_ctrl[1], 0);
      chk(pll_ctrl[0] == 1'b1, "R8 disable ignored while busy", pll_ctrl[0], 1);

      // R3 / R5 full relock path with an intruding request (R8)
      strobe(1, 40, 2);
      chk(pll_ctrl[1] && !pll_ctrl[2] && pll_ctrl[27:20] == 8'(FB_INIT), "R3 step1 bypass", pll_ctrl, 0);
      @(negedge clk);
      chk(pll_ctrl[2] && pll_ctrl[27:20] == 8'(FB_INIT), "R3 step2 reset", pll_ctrl, 0);
      @(negedge clk);
      chk(pll_ctrl[2] && pll_ctrl[27:20] == 8'd40 && pll_ctrl[18:16] == 3'd2, "R3 step3 program", pll_ctrl, 0);
      rate_req = 1; rate_fb = 8'd99;
      @(negedge clk);
      rate_req = 0;
      chk(!pll_ctrl[2], "R3 step4 release", pll_ctrl[2], 0);
      wait_done("R5 relock done");
      chk(pll_ctrl[1:0] == 2'b01, "R5 enable and unpark together", pll_ctrl[1:0], 2'b01);
      chk(pll_ctrl[27:20] == 8'd40, "R8 request while busy ignored", pll_ctrl[27:20], 40);
      @(negedge clk);

      // R4 late flag ahead of lock
      late_first = 1;
      strobe(1, 50, 0);
      begin
         bit lock_seen = 0;
         int n = 0;
         while (!done && n < 200) begin
            if (pll_lock) lock_seen = 1;
            @(negedge clk); n++;
         end
         chk(done && lock_seen, "R4 waits for lock first", lock_seen, 1);
      end
      late_first = 0;
      @(negedge clk);

      // R9 timeout
      kill = 1; tmo_limit = 16'd5;
      strobe(1, 77, 3);
      wait_done("R9 abort done");
      chk(err && pll_ctrl[1], "R9 abort parks", {err, pll_ctrl[1]}, 2'b11);
      tmo_limit = 16'd0;
      strobe(2, 0, 0);
      repeat (60) @(negedge clk);
      chk(busy && !done, "R9 limit zero waits", busy, 1);
      kill = 0;
      wait_done("R9 recovery done");
      chk(!err, "R9 error cleared", err, 0);
      @(negedge clk);

      // R10 priority
      strobe(4, 0, 0);
      strobe(16, 0, 0);
      chk(pll_ctrl[2] && !pll_ctrl[0], "R10 setup", pll_ctrl[2:0], 0);
      strobe(2 | 8, 0, 0);
      wait_done("R10 prepare beats enable");
      chk(!pll_ctrl[0], "R10 enable lost", pll_ctrl[0], 0);
      @(negedge clk);
      strobe(4 | 8, 0, 0);
      chk(pll_ctrl[2] && !pll_ctrl[0], "R10 unprepare beats enable", pll_ctrl[2:0], 3'b100);
      strobe(1 | 2, 77, 6);
      chk(busy && pll_ctrl[1], "R10 rate beats prepare", pll_ctrl[1], 1);
      @(negedge clk);
      chk(pll_ctrl[18:16] == 3'd6 && pll_ctrl[2], "R10 short path taken", pll_ctrl[18:16], 6);
      repeat (4) @(negedge clk);
      summary();
   end
endmodule